// File: doc/BRIEF.md
# Three-Channel Audio Interval Timer

This block gives an audio coprocessor three independent interval timers. Each channel is a chain of three stages. A shared prescaler, which is never reset after power-up, divides the processor's cycle pulses. An 8-bit stage counter then advances on every prescaler tick and is compared with a programmable target. A 4-bit result counter advances on each match, and software reads it. Reading the result counter returns its value and clears it, so software can poll it to learn how many intervals have passed since its last look.

Channels 0 and 1 use the slow prescaler output. Channel 2 uses the fast one. A control write turns channels on or off. Turning a channel on clears its stage counter and its result counter, but the prescaler phase is kept. The channel's first interval can therefore be shorter than the ones that follow it. The target registers and the control register cannot be read back.

Top module: `sound_timer_unit`

## Requirements
- R1: A prescaler counts `cycle_tick` pulses from reset. Channels 0 and 1 receive a tick on every SLOW_DIV-th pulse and channel 2 on every FAST_DIV-th pulse. Pulse number k (counted from 1 after reset) produces a slow tick when k is a multiple of SLOW_DIV and a fast tick when k is a multiple of FAST_DIV.
- R2: An enabled channel adds one to its 8-bit stage counter on each of its ticks. When the incremented value equals the channel's target, the result counter goes up by one and the stage counter restarts from 0.
- R3: A target of 0 gives a divide ratio of 256, and the target registers reset to 0.
- R4: A read of result counter n (address 4+n) returns its value in bits 3:0, with bits 7:4 at zero. The read also clears that counter but leaves the stage counter untouched.
- R5: A write to result counter n's address clears that counter, whatever data is written.
- R6: Setting control bit n from 0 to 1 clears channel n's stage counter and result counter. The prescaler phase is not changed.
- R7: If the target is lowered below the current stage count, the next match happens only after the stage counter has wrapped from 255 to 0 and climbed back up to the new target.
- R8: While a channel is disabled, its stage counter and result counter keep their values.
- R9: The 4-bit result counter wraps from 15 to 0.
- R10: If a clear and a match of the same result counter fall in the same cycle, the clear wins and that increment is lost.
- R11: A read of the control address (0) or of a target address (1+n) returns 0.
- R12: Address map: control at 0, with bit n enabling channel n; target of channel n at 1+n; result counter of channel n at 4+n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_tick | input | 1 | One pulse per coprocessor cycle |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (read clears a result counter) |
| bus_rdata | output | 8 | Read data, valid in the same cycle as bus_rd |

## Verification
The bench builds the block with SLOW_DIV=8 and FAST_DIV=2 and drives `cycle_tick` as single pulses under its own control. Every tick therefore falls on a pulse count the bench already knows. These small divisors bring a full 256-step stage wrap, with a target of 0 or a lowered target, within about two thousand pulses. They also make it cheap to check a 16-count result wrap and a first interval that keeps the prescaler phase across an enable. With the pulses under bench control, a read can be placed in exactly the cycle where a match lands, which exercises the clear-wins case.

// File: rtl/sts_pkg.sv
package sts_pkg;

  localparam int STAGE_W = 8;
  localparam int RES_W   = 4;
  localparam int DATA_W  = 8;

  // Advance a stage counter by one tick. Bit STAGE_W is the match flag;
  // the low bits are the next stage value (0 after a match).
  function automatic logic [STAGE_W:0] sts_advance(
    input logic [STAGE_W-1:0] cur,
    input logic [STAGE_W-1:0] tgt
  );
    logic [STAGE_W-1:0] inc;
    inc = cur + STAGE_W'(1);
    if (inc == tgt) return {1'b1, {STAGE_W{1'b0}}};
    return {1'b0, inc};
  endfunction

  // Result counter step, wrapping modulo 2**RES_W.
  function automatic logic [RES_W-1:0] sts_bump(input logic [RES_W-1:0] v);
    return v + RES_W'(1);
  endfunction

  // Is this prescaler count the last one of a period of length div?
  function automatic logic sts_period_end(input int unsigned cnt, input int unsigned div);
    return (cnt % div) == (div - 1);
  endfunction

endpackage

// File: rtl/sts_prescaler.sv
module sts_prescaler #(
  parameter int SLOW_DIV = 128,
  parameter int FAST_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_tick,
  output logic slow_tick,
  output logic fast_tick
);
  import sts_pkg::*;

  localparam int PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic [PW-1:0] pcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (cycle_tick) begin
      if (pcnt == PW'(SLOW_DIV - 1)) pcnt <= '0;
      else                           pcnt <= pcnt + PW'(1);
    end
  end

  assign slow_tick = cycle_tick && sts_period_end(int'(pcnt), SLOW_DIV);
  assign fast_tick = cycle_tick && sts_period_end(int'(pcnt), FAST_DIV);

endmodule

// File: rtl/sts_channel.sv
module sts_channel (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tick,
  input  logic                        en,
  input  logic                        rise,
  input  logic                        tgt_we,
  input  logic [sts_pkg::DATA_W-1:0]  wdata,
  input  logic                        clr,
  output logic [sts_pkg::STAGE_W-1:0] stage_cnt,
  output logic [sts_pkg::RES_W-1:0]   res_cnt,
  output logic                        match
);
  import sts_pkg::*;

  logic [STAGE_W-1:0] target;
  logic [STAGE_W:0]   adv;

  assign adv   = sts_advance(stage_cnt, target);
  assign match = en && tick && adv[STAGE_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target    <= '0;
      stage_cnt <= '0;
      res_cnt   <= '0;
    end else begin
      if (tgt_we) target <= wdata[STAGE_W-1:0];

      if (rise)             stage_cnt <= '0;
      else if (en && tick)  stage_cnt <= adv[STAGE_W-1:0];

      if (rise || clr)      res_cnt <= '0;
      else if (match)       res_cnt <= sts_bump(res_cnt);
    end
  end

endmodule

// File: rtl/sts_regbus.sv
module sts_regbus #(
  parameter int N_CH   = 3,
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [N_CH*sts_pkg::RES_W-1:0] res_flat,
  output logic                          ctrl_we,
  output logic [N_CH-1:0]               tgt_we,
  output logic [N_CH-1:0]               res_clr,
  output logic [sts_pkg::DATA_W-1:0]    rdata
);
  import sts_pkg::*;

  localparam int TGT_BASE = 1;
  localparam int RES_BASE = 1 + N_CH;

  assign ctrl_we = bus_wr && (bus_addr == ADDR_W'(0));

  logic [N_CH-1:0]        rd_hit;
  logic [DATA_W-1:0]      rd_part [N_CH];

  for (genvar g = 0; g < N_CH; g++) begin : g_dec
    assign tgt_we[g]  = bus_wr && (bus_addr == ADDR_W'(TGT_BASE + g));
    assign rd_hit[g]  = bus_rd && (bus_addr == ADDR_W'(RES_BASE + g));
    assign res_clr[g] = rd_hit[g] || (bus_wr && (bus_addr == ADDR_W'(RES_BASE + g)));
    assign rd_part[g] = rd_hit[g] ? {{(DATA_W-RES_W){1'b0}}, res_flat[g*RES_W +: RES_W]}
                                  : '0;
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_CH; i++) rdata = rdata | rd_part[i];
  end

endmodule

// File: rtl/sound_timer_unit.sv
module sound_timer_unit #(
  parameter int N_CH      = 3,
  parameter int FAST_MASK = 3'b100,
  parameter int SLOW_DIV  = 128,
  parameter int FAST_DIV  = 16,
  parameter int ADDR_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cycle_tick,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [sts_pkg::DATA_W-1:0] bus_wdata,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  output logic [sts_pkg::DATA_W-1:0] bus_rdata
);
  import sts_pkg::*;

  // Named internal events, visible to the bound checker.
  logic                   slow_tick, fast_tick;
  logic                   ctrl_we;
  logic [N_CH-1:0]        en_q;
  logic [N_CH-1:0]        tick_vec, rise_vec, match_vec, clr_vec, tgt_we;
  logic [N_CH*STAGE_W-1:0] stage_flat;
  logic [N_CH*RES_W-1:0]   res_flat;

  sts_prescaler #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick),
    .slow_tick(slow_tick), .fast_tick(fast_tick)
  );

  sts_regbus #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_bus (
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .res_flat(res_flat), .ctrl_we(ctrl_we), .tgt_we(tgt_we),
    .res_clr(clr_vec), .rdata(bus_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       en_q <= '0;
    else if (ctrl_we) en_q <= bus_wdata[N_CH-1:0];
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    if (FAST_MASK[g]) begin : g_fast
      assign tick_vec[g] = fast_tick;
    end else begin : g_slow
      assign tick_vec[g] = slow_tick;
    end

    assign rise_vec[g] = ctrl_we && bus_wdata[g] && !en_q[g];

    sts_channel u_ch (
      .clk(clk), .rst_n(rst_n), .tick(tick_vec[g]), .en(en_q[g]),
      .rise(rise_vec[g]), .tgt_we(tgt_we[g]), .wdata(bus_wdata),
      .clr(clr_vec[g]),
      .stage_cnt(stage_flat[g*STAGE_W +: STAGE_W]),
      .res_cnt(res_flat[g*RES_W +: RES_W]),
      .match(match_vec[g])
    );
  end

endmodule

// File: rtl/sts_checker.sv
module sts_checker #(
  parameter int N_CH   = 3,
  parameter int ADDR_W = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          slow_tick,
  input logic                          fast_tick,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic                          bus_rd,
  input logic [sts_pkg::DATA_W-1:0]    bus_rdata,
  input logic [N_CH-1:0]               en_q,
  input logic [N_CH-1:0]               rise_vec,
  input logic [N_CH-1:0]               match_vec,
  input logic [N_CH-1:0]               clr_vec,
  input logic [N_CH*sts_pkg::STAGE_W-1:0] stage_flat,
  input logic [N_CH*sts_pkg::RES_W-1:0]   res_flat
);
  import sts_pkg::*;

  AST_SLOW_IN_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    slow_tick |-> fast_tick); // R1

  AST_HIDDEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr < ADDR_W'(1 + N_CH)) |-> bus_rdata == '0); // R11

  for (genvar g = 0; g < N_CH; g++) begin : g_chk
    AST_MATCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (match_vec[g] && !clr_vec[g] && !rise_vec[g])
      |=> res_flat[g*RES_W +: RES_W] == $past(res_flat[g*RES_W +: RES_W]) + RES_W'(1)); // R9

    AST_MATCH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      match_vec[g] |=> stage_flat[g*STAGE_W +: STAGE_W] == '0); // R2

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      clr_vec[g] |=> res_flat[g*RES_W +: RES_W] == '0); // R10

    AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      rise_vec[g] |=> (stage_flat[g*STAGE_W +: STAGE_W] == '0 &&
                       res_flat[g*RES_W +: RES_W] == '0)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[g] && !rise_vec[g] && !clr_vec[g])
      |=> ($stable(stage_flat[g*STAGE_W +: STAGE_W]) &&
           $stable(res_flat[g*RES_W +: RES_W]))); // R8

    AST_NO_MATCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q[g] |-> !match_vec[g]); // R8
  end

endmodule

bind sound_timer_unit sts_checker #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_sts_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .fast_tick(fast_tick),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .en_q(en_q), .rise_vec(rise_vec), .match_vec(match_vec), .clr_vec(clr_vec),
  .stage_flat(stage_flat), .res_flat(res_flat)
);

// File: tb/sound_timer_unit_tb_top.sv
module sound_timer_unit_tb_top;

  localparam int SDIV = 8;
  localparam int FDIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cycle_tick = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_rdata;

  int n_vec = 0;
  int n_bad = 0;
  int total_pulses = 0;
  int exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  sound_timer_unit #(.SLOW_DIV(SDIV), .FAST_DIV(FDIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  // Monitor: samples mid-way through the cycle in which bus_rd is driven.
  always @(negedge clk) begin
    #5;
    if (bus_rd) begin
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL scoreboard: read with no expected item, actual %0d expected none", bus_rdata);
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_vec++;
        if (int'(bus_rdata) != e) begin
          n_bad++;
          $display("FAIL %s: actual %0d expected %0d", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) cycle_tick = 1'b1;
      total_pulses++;
    end
    @(negedge clk) cycle_tick = 1'b0;
  endtask

  task automatic align();
    if (total_pulses % SDIV != 0) pulse(SDIV - (total_pulses % SDIV));
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk) begin bus_addr = 3'(a); bus_wdata = 8'(d); bus_wr = 1'b1; end
    @(negedge clk) bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input int e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk) begin bus_addr = 3'(a); bus_rd = 1'b1; end
    @(negedge clk) bus_rd = 1'b0;
  endtask

  // Read a result counter in the same cycle as a prescaler pulse.
  task automatic rd_with_pulse(input int a, input int e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk) begin bus_addr = 3'(a); bus_rd = 1'b1; cycle_tick = 1'b1; end
    total_pulses++;
    @(negedge clk) begin bus_rd = 1'b0; cycle_tick = 1'b0; end
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state, write-only registers read zero
    rd(4, 0, "R4 reset ch0");
    rd(5, 0, "R4 reset ch1");
    rd(6, 0, "R4 reset ch2");
    rd(0, 0, "R11 control read");
    rd(1, 0, "R11 target read");

    // Basic division on all channels, R1 R2 R12
    wr(1, 3); wr(2, 0); wr(3, 4);
    rd(3, 0, "R11 target after write");
    wr(0, 7);
    pulse(24);
    rd(4, 1, "R2 ch0 target 3 after 3 slow ticks");
    rd(6, 3, "R1 ch2 fast ticks 12 target 4");
    rd(5, 0, "R1 ch1 still counting");

    // Read clears the result but not the stage counter, R4
    wr(0, 0); wr(0, 1);
    pulse(16);
    rd(4, 0, "R4 read mid interval");
    pulse(8);
    rd(4, 1, "R4 stage count survived read");
    rd(4, 0, "R4 cleared by read");

    // Write clears, R5
    pulse(24);
    wr(4, 8'hA5);
    rd(4, 0, "R5 write clears result");

    // Target 0 divides by 256, R3
    wr(0, 0); align(); wr(0, 2);
    pulse(255 * SDIV);
    rd(5, 0, "R3 before 256th tick");
    pulse(SDIV);
    rd(5, 1, "R3 on 256th tick");

    // Result wrap, R9
    wr(0, 0); wr(3, 1); align(); wr(0, 4);
    pulse(30);
    rd(6, 15, "R9 fifteen counts");
    wr(0, 0); align(); wr(0, 4);
    pulse(34);
    rd(6, 1, "R9 seventeen counts wraps");

    // Lowered target forces a wrap, R7
    wr(0, 0); wr(1, 10); align(); wr(0, 1);
    pulse(6 * SDIV);
    wr(1, 3);
    pulse(252 * SDIV);
    rd(4, 0, "R7 no match before wrap");
    pulse(SDIV);
    rd(4, 1, "R7 match after wrap");

    // Enable rise clears, prescaler phase kept, R6
    wr(1, 1);
    pulse(SDIV);
    wr(0, 0); wr(0, 1);
    rd(4, 0, "R6 rise clears result");
    wr(0, 0); align();
    pulse(5);
    wr(0, 1);
    pulse(3);
    rd(4, 1, "R6 prescaler phase kept");

    // Disabled channel holds, R8
    pulse(2 * SDIV);
    wr(0, 0);
    pulse(10 * SDIV);
    rd(4, 2, "R8 result held while disabled");

    // Clear beats simultaneous match, R10
    wr(0, 0); align(); wr(0, 1);
    pulse(SDIV - 1);
    rd_with_pulse(4, 0, "R10 read at match");
    rd(4, 0, "R10 increment lost");
    pulse(SDIV);
    rd(4, 1, "R10 next match counts");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule